// File: doc/BRIEF.md
# Clock Alarm and Interrupt Flag Unit

This unit sits next to the seconds/minutes/hours counters of a real-time clock. It keeps three sticky event flags and a summary interrupt flag. The first event flag marks each finished once-per-second update. The second marks a time that equals the programmed alarm. The third marks a tick from the periodic divider. The unit combines the flags with three enable bits and drives a single active-high interrupt line. Software clears all flags at once by reading the status byte.

On every accepted update strobe, the alarm is checked against the time the counters present in that cycle. Each alarm field can be set to "any value". Hours are brought to a common 0..23 form before the compare, so the 12-hour/24-hour setting and the BCD/binary setting give the same result for the same wall-clock time. Counting time, bus address decode and wake-up signalling are done outside this unit.

Top module: `rtc_alarm_irq`

## Requirements
- R1: An alarm byte whose bits 7 and 6 are both 1 matches any current value of its field (seconds, minutes or hours).
- R2: Every accepted update strobe sets the update flag, bit 4 of the status byte.
- R3: An accepted update strobe sets the alarm flag, bit 5, when every non-wildcard alarm field equals the current field.
- R4: Fields are decoded as binary when `bin_mode_i` is 1 and as BCD otherwise. When `hr24_i` is 0, an hour byte holds 1..12 in its low seven bits and bit 7 marks PM. A 12-hour value and its 24-hour equivalent are treated as equal.
- R5: A tick on `tick_i` sets the periodic flag, bit 6. A flag that goes from clear to set while its enable is on sets the summary flag, bit 7, and `irq_o` one cycle later. The enables are bit 4 for update, bit 5 for alarm and bit 6 for periodic in the enable write byte.
- R6: While `flag_rd_i` is high, `flags_o` shows the current flags. After that edge all flags are clear and `irq_o` is low, unless a new event arrives in the same cycle.
- R7: An enable write raises bit 7 and `irq_o` at once if any pending flag has its enable set in the written byte. Otherwise it clears bit 7 and lowers `irq_o`. Flags that are already pending stay set.
- R8: Reset clears all flags, the summary flag, `irq_o` and all enables.
- R9: While `div_hold_i` is high, update strobes are ignored, so neither the update flag nor the alarm flag is set.
- R10: Bits 3..0 of `flags_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_done_i | input | 1 | One-cycle strobe: the once-per-second update has finished |
| tick_i | input | 1 | One-cycle periodic tick |
| div_hold_i | input | 1 | The divider chain is held in reset |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = BCD fields |
| hr24_i | input | 1 | 1 = 24-hour format, 0 = 12-hour with PM in bit 7 |
| now_sec_i | input | TIME_W | Current seconds |
| now_min_i | input | TIME_W | Current minutes |
| now_hour_i | input | TIME_W | Current hours |
| alm_sec_i | input | TIME_W | Alarm seconds |
| alm_min_i | input | TIME_W | Alarm minutes |
| alm_hour_i | input | TIME_W | Alarm hours |
| ien_we_i | input | 1 | Write strobe for the enable byte |
| ien_wdata_i | input | 8 | Enable byte: bit 4 update, bit 5 alarm, bit 6 periodic |
| flag_rd_i | input | 1 | Status byte read strobe (read clears) |
| flags_o | output | 8 | Status byte: 7 summary, 6 periodic, 5 alarm, 4 update, 3..0 zero |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench uses the default configuration: 8-bit fields with the periodic flag present. With this width every BCD and binary encoding of a time of day fits, so the bench can sweep all 24×24 pairs of current hour and alarm hour in each of the four format combinations. It also covers all eight wildcard patterns across the three fields, both with exact values and with mismatched ones. Short directed sequences then check the enable write, read-clear, divider hold and reset rules.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
   // event vector index order, also matches enable byte bits 4..6
   localparam int EV_UPD = 0;
   localparam int EV_ALM = 1;
   localparam int EV_PER = 2;
   localparam int EV_N   = 3;
   // status byte bit positions
   localparam int ST_UPD = 4;
   localparam int ST_SUM = 7;
   // number of compared time fields (sec, min, hour)
   localparam int N_FIELDS = 3;
   localparam int HOUR_IDX = 2;
   typedef logic [EV_N-1:0] ev_vec_t;
endpackage

// File: rtl/rtc_field_norm.sv
module rtc_field_norm #(
   parameter int W       = 8,
   parameter bit IS_HOUR = 1'b0
) (
   input  logic [W-1:0] raw_i,
   input  logic         bin_mode_i,
   input  logic         hr24_i,
   output logic [W-1:0] val_o,
   output logic         wild_o
);
   logic [W-1:0] body;
   logic [W-1:0] dec;

   assign wild_o = raw_i[W-1] & raw_i[W-2];

   generate
      if (IS_HOUR) begin : g_hour
         always_comb begin
            body = hr24_i ? raw_i : {1'b0, raw_i[W-2:0]};
            dec  = bin_mode_i ? body
                              : W'(W'(body[W-1:4]) * W'(10) + W'(body[3:0]));
            if (hr24_i)
               val_o = dec;
            else
               val_o = W'(dec % W'(12)) + (raw_i[W-1] ? W'(12) : W'(0));
         end
      end else begin : g_plain
         always_comb begin
            body  = raw_i;
            dec   = bin_mode_i ? body
                               : W'(W'(body[W-1:4]) * W'(10) + W'(body[3:0]));
            val_o = dec;
         end
      end
   endgenerate
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_alm_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [N_FIELDS-1:0][W-1:0] now_i,
   input  logic [N_FIELDS-1:0][W-1:0] alm_i,
   input  logic                       bin_mode_i,
   input  logic                       hr24_i,
   output logic                       match_o
);
   logic [N_FIELDS-1:0] field_ok;

   generate
      for (genvar f = 0; f < N_FIELDS; f++) begin : g_fld
         logic [W-1:0] now_v, alm_v;
         logic         now_wild_unused, alm_wild;
         rtc_field_norm #(.W(W), .IS_HOUR(f == HOUR_IDX)) u_now (
            .raw_i(now_i[f]), .bin_mode_i(bin_mode_i), .hr24_i(hr24_i),
            .val_o(now_v), .wild_o(now_wild_unused));
         rtc_field_norm #(.W(W), .IS_HOUR(f == HOUR_IDX)) u_alm (
            .raw_i(alm_i[f]), .bin_mode_i(bin_mode_i), .hr24_i(hr24_i),
            .val_o(alm_v), .wild_o(alm_wild));
         assign field_ok[f] = alm_wild | (now_v == alm_v);
      end
   endgenerate

   assign match_o = &field_ok;
endmodule

// File: rtl/rtc_flag_core.sv
module rtc_flag_core
   import rtc_alm_pkg::*;
#(
   parameter bit HAS_PERIODIC = 1'b1
) (
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    upd_i,
   input  logic    alm_hit_i,
   input  logic    tick_i,
   input  logic    en_we_i,
   input  ev_vec_t en_wdata_i,
   input  logic    rd_i,
   output ev_vec_t flag_o,
   output logic    sum_o
);
   ev_vec_t flag_q, en_q, set_v, pend, fresh, en_d;
   logic    sum_q, sum_base, tick_eff;

   generate
      if (HAS_PERIODIC) begin : g_per
         assign tick_eff = tick_i;
      end else begin : g_noper
         logic tick_unused;
         assign tick_unused = tick_i;
         assign tick_eff    = 1'b0;
      end
   endgenerate

   always_comb begin
      set_v         = '0;
      set_v[EV_UPD] = upd_i;
      set_v[EV_ALM] = upd_i & alm_hit_i;
      set_v[EV_PER] = tick_eff;
      pend          = rd_i ? '0 : flag_q;
      fresh         = set_v & ~pend;
      en_d          = en_we_i ? en_wdata_i : en_q;
      if (en_we_i)
         sum_base = |(en_wdata_i & pend);
      else
         sum_base = rd_i ? 1'b0 : sum_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= '0;
         en_q   <= '0;
         sum_q  <= 1'b0;
      end else begin
         flag_q <= pend | set_v;
         en_q   <= en_d;
         sum_q  <= sum_base | (|(fresh & en_d));
      end
   end

   assign flag_o = flag_q;
   assign sum_o  = sum_q;

   // summary flag never stands without a pending event flag
   assert_sum_has_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sum_q |-> (|flag_q));
   // interrupt only rises after an event or an enable write
   assert_sum_rise_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sum_q) |-> $past(en_we_i | upd_i | tick_eff));
   // read with no new event leaves everything clear
   assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !upd_i && !tick_eff) |=> (flag_q == '0) && !sum_q);
   // each accepted update leaves the update flag set
   assert_update_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_i |=> flag_q[EV_UPD]);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
   import rtc_alm_pkg::*;
#(
   parameter int TIME_W       = 8,
   parameter bit HAS_PERIODIC = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              upd_done_i,
   input  logic              tick_i,
   input  logic              div_hold_i,
   input  logic              bin_mode_i,
   input  logic              hr24_i,
   input  logic [TIME_W-1:0] now_sec_i,
   input  logic [TIME_W-1:0] now_min_i,
   input  logic [TIME_W-1:0] now_hour_i,
   input  logic [TIME_W-1:0] alm_sec_i,
   input  logic [TIME_W-1:0] alm_min_i,
   input  logic [TIME_W-1:0] alm_hour_i,
   input  logic              ien_we_i,
   input  logic [7:0]        ien_wdata_i,
   input  logic              flag_rd_i,
   output logic [7:0]        flags_o,
   output logic              irq_o
);
   localparam int EN_LSB = ST_UPD;

   generate
      if (TIME_W < 8) begin : g_bad_width
         $error("rtc_alarm_irq: TIME_W must be at least 8");
      end
   endgenerate

   logic [N_FIELDS-1:0][TIME_W-1:0] now_v, alm_v;
   logic    alm_hit, upd_ok, sum;
   ev_vec_t flag;
   logic [7:0] en_unused;

   assign now_v     = {now_hour_i, now_min_i, now_sec_i};
   assign alm_v     = {alm_hour_i, alm_min_i, alm_sec_i};
   assign upd_ok    = upd_done_i & ~div_hold_i;
   assign en_unused = ien_wdata_i;

   rtc_alarm_cmp #(.W(TIME_W)) u_cmp (
      .now_i(now_v), .alm_i(alm_v),
      .bin_mode_i(bin_mode_i), .hr24_i(hr24_i),
      .match_o(alm_hit));

   rtc_flag_core #(.HAS_PERIODIC(HAS_PERIODIC)) u_core (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .upd_i(upd_ok), .alm_hit_i(alm_hit), .tick_i(tick_i),
      .en_we_i(ien_we_i), .en_wdata_i(ien_wdata_i[EN_LSB +: EV_N]),
      .rd_i(flag_rd_i),
      .flag_o(flag), .sum_o(sum));

   assign flags_o = {sum, flag[EV_PER], flag[EV_ALM], flag[EV_UPD], 4'b0000};
   assign irq_o   = sum;

   // a held divider never brings a new update flag
   assert_hold_blocks_upd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_hold_i && !flags_o[ST_UPD]) |=> !flags_o[ST_UPD]);
   // the interrupt line and the summary bit agree
   assert_irq_matches_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == flags_o[ST_SUM]);
endmodule

// File: tb/rtc_alarm_irq_tb_top.sv
module rtc_alarm_irq_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upd = 1'b0, tick = 1'b0, hold = 1'b0, bin = 1'b0, h24 = 1'b1;
   logic [7:0] ns = 8'h0, nm = 8'h0, nh = 8'h0, as_ = 8'h0, am = 8'h0, ah = 8'h0;
   logic en_we = 1'b0, rd = 1'b0;
   logic [7:0] en_wd = 8'h0;
   logic [7:0] flags;
   logic irq;
   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rtc_alarm_irq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .upd_done_i(upd), .tick_i(tick),
      .div_hold_i(hold), .bin_mode_i(bin), .hr24_i(h24),
      .now_sec_i(ns), .now_min_i(nm), .now_hour_i(nh),
      .alm_sec_i(as_), .alm_min_i(am), .alm_hour_i(ah),
      .ien_we_i(en_we), .ien_wdata_i(en_wd), .flag_rd_i(rd),
      .flags_o(flags), .irq_o(irq));

   function automatic logic [7:0] enc(input int v, input bit b);
      return b ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [7:0] enc_h(input int h, input bit b, input bit t24);
      int h12;
      if (t24) return enc(h, b);
      h12 = (h % 12 == 0) ? 12 : h % 12;
      return enc(h12, b) | (h >= 12 ? 8'h80 : 8'h00);
   endfunction

   task automatic chk(input string req, input logic [7:0] act_f, input logic act_i,
                      input logic [7:0] exp_f, input logic exp_i);
      checks++;
      if (act_f !== exp_f || act_i !== exp_i) begin
         errors++;
         $display("FAIL %s: flags=%02h irq=%0b expected flags=%02h irq=%0b",
                  req, act_f, act_i, exp_f, exp_i);
      end
   endtask

   task automatic pulse_upd();
      @(negedge clk); upd = 1'b1;
      @(negedge clk); upd = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic wr_en(input logic [7:0] d);
      @(negedge clk); en_we = 1'b1; en_wd = d;
      @(negedge clk); en_we = 1'b0;
   endtask

   task automatic do_read(input string req, input bit chk_pre, input logic [7:0] pre);
      @(negedge clk); rd = 1'b1;
      if (chk_pre) chk(req, flags, irq, pre, pre[7]);
      @(negedge clk); rd = 1'b0;
      if (chk_pre) chk("R6 after read", flags, irq, 8'h00, 1'b0);
   endtask

   task automatic set_now(input int h, input int m, input int s);
      nh = enc_h(h, bin, h24); nm = enc(m, bin); ns = enc(s, bin);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset state", flags, irq, 8'h00, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 / R3: all current vs alarm hour pairs in all four formats
      for (int mode = 0; mode < 4; mode++) begin
         bin = mode[0]; h24 = mode[1];
         for (int hc = 0; hc < 24; hc++) begin
            for (int ha = 0; ha < 24; ha++) begin
               set_now(hc, 30, 15);
               ah = enc_h(ha, bin, h24); am = enc(30, bin); as_ = enc(15, bin);
               pulse_upd();
               chk("R4 R3 hour compare", flags, irq,
                   (ha == hc) ? 8'h30 : 8'h10, 1'b0);
               do_read("R6", 1'b0, 8'h00);
            end
         end
      end

      // R1: wildcard patterns over the three fields
      for (int mode = 0; mode < 4; mode++) begin
         bin = mode[0]; h24 = mode[1];
         for (int mask = 0; mask < 8; mask++) begin
            for (int exact = 0; exact < 2; exact++) begin
               set_now(17, 42, 9);
               as_ = mask[0] ? 8'hC0 : enc(exact != 0 ? 9 : 10, bin);
               am  = mask[1] ? 8'hFF : enc(exact != 0 ? 42 : 43, bin);
               ah  = mask[2] ? 8'hC5 : enc_h(exact != 0 ? 17 : 18, bin, h24);
               pulse_upd();
               chk("R1 wildcard", flags, irq,
                   (exact != 0 || mask == 7) ? 8'h30 : 8'h10, 1'b0);
               checks++;
               if (flags[3:0] !== 4'h0) begin
                  errors++;
                  $display("FAIL R10: low nibble=%0h expected 0", flags[3:0]);
               end
               do_read("R6", 1'b0, 8'h00);
            end
         end
      end

      // directed interrupt sequences, BCD 24-hour
      bin = 1'b0; h24 = 1'b1;
      set_now(8, 0, 0);
      ah = enc(9, 0); am = enc(0, 0); as_ = enc(0, 0);
      wr_en(8'h00);
      pulse_upd();
      chk("R2 update flag only", flags, irq, 8'h10, 1'b0);
      wr_en(8'h20);
      chk("R7 enable without pending match", flags, irq, 8'h10, 1'b0);
      set_now(9, 0, 0);
      pulse_upd();
      chk("R5 R3 alarm with enable", flags, irq, 8'hB0, 1'b1);
      do_read("R6 read value", 1'b1, 8'hB0);
      set_now(9, 0, 1);
      pulse_upd();
      chk("R5 update not enabled", flags, irq, 8'h10, 1'b0);
      wr_en(8'h10);
      chk("R7 immediate on pending", flags, irq, 8'h90, 1'b1);
      wr_en(8'h00);
      chk("R7 clear on disable", flags, irq, 8'h10, 1'b0);
      wr_en(8'h40);
      pulse_tick();
      chk("R5 periodic flag", flags, irq, 8'hD0, 1'b1);
      do_read("R6 read periodic", 1'b1, 8'hD0);

      // R9: held divider ignores updates
      hold = 1'b1;
      wr_en(8'h30);
      set_now(9, 0, 0);
      pulse_upd();
      chk("R9 hold blocks update", flags, irq, 8'h00, 1'b0);
      hold = 1'b0;
      pulse_upd();
      chk("R9 release resumes", flags, irq, 8'hB0, 1'b1);

      // R8: reset mid-run clears flags and enables
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R8 reset clears flags", flags, irq, 8'h00, 1'b0);
      rst_n = 1'b1;
      pulse_upd();
      chk("R8 enables cleared", flags, irq, 8'h30, 1'b0);
      checks++;
      if (flags[3:0] !== 4'h0) begin
         errors++;
         $display("FAIL R10: low nibble=%0h expected 0", flags[3:0]);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule